// File: doc/BRIEF.md
# Two-Lane Interleaved Delay Line

This block delays a W-bit sample stream by exactly N clock cycles. Seen from its ports it behaves like a plain serial register chain of N stages. Inside, the chain is split into two lanes of N/2 stages each.

A one-bit phase register flips on every clock. Each incoming sample is written into the lane that the phase selects, so a lane advances only on every second cycle and holds every other sample. The output is taken from the tail of the lane that the phase currently selects. A sample written into a lane on a given cycle reaches that lane's tail after N/2 of its own shifts. The phase then points at that lane again, exactly N cycles after the write.

The block is a drop-in replacement for a long full-rate delay chain where only half of the storage should toggle on any cycle. The cost is a steering decode at the input and a 2:1 multiplexer at the output.

Top module: `ilsr_top`

## Requirements
- R1: Once the pipeline has filled, `dout` in cycle c equals the `din` value presented in cycle c-N, for every cycle and any data.
- R2: For the first N cycles after synchronous reset is released, `dout` is all zeros. Cycle 0 is the first cycle with `rst` low.
- R3: Asserting `rst` while the line holds data discards all stored samples. After release, the output again shows N cycles of zeros, followed by only the data presented after the reset.
- R4: Samples are steered alternately. The phase bit is 0 in cycle 0 after reset and inverts on every clock. The lane not selected in a cycle keeps its contents. A lone nonzero sample among zeros comes out exactly N cycles later, whether it enters on an even or an odd cycle, and the output is zero in every other cycle.
- R5: Consecutive distinct samples leave in their original order, with none skipped, repeated or swapped between lanes.
- R6: All W bits are carried independently. All-ones, all-zeros and walking-one patterns come out unchanged, and `dout` is never unknown after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input     | 1     | Clock; all state updates on the rising edge |
| rst  | input     | 1     | Synchronous reset, active high; clears both lanes and the phase |
| din  | input     | W     | Sample entering the delay line this cycle |
| dout | output    | W     | Sample that entered N cycles earlier |

## Verification
In every cycle, the lane whose tail drives the output is the same lane that accepts the new sample at the next edge. Reading out the oldest sample and writing the newest one therefore always fall in the same cycle of the same lane. This is provoked with a ramp of distinct back-to-back values and with single pulses entering on even and on odd cycles. Each output is judged against a history of driven inputs taken N cycles back. A reset is also issued while the line is full, so that reset and pending data meet in one cycle, and the following zero-fill is checked.

// File: rtl/ilsr_pkg.sv
package ilsr_pkg;

    // Which of the two lanes the steering phase selects.
    typedef enum logic {
        LANE_EVEN = 1'b0,
        LANE_ODD  = 1'b1
    } lane_e;

    function automatic lane_e lane_flip(lane_e cur);
        return (cur == LANE_EVEN) ? LANE_ODD : LANE_EVEN;
    endfunction

endpackage

// File: rtl/ilsr_phase.sv
module ilsr_phase
    import ilsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output lane_e phase_o
);
    typedef struct packed {
        lane_e phase;
    } phase_state_t;

    phase_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = lane_flip(st_q.phase);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= LANE_EVEN;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

endmodule

// File: rtl/ilsr_lane.sv
module ilsr_lane #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] tail_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stage;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.stage[0] = din_i;
            for (int k = 1; k < DEPTH; k++) begin
                st_d.stage[k] = st_q.stage[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail_o = st_q.stage[DEPTH-1];

endmodule

// File: rtl/ilsr_merge.sv
module ilsr_merge
    import ilsr_pkg::*;
#(
    parameter int W = 8
) (
    input  lane_e        sel_i,
    input  logic [W-1:0] even_i,
    input  logic [W-1:0] odd_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (sel_i)
            LANE_EVEN: y_o = even_i;
            LANE_ODD:  y_o = odd_i;
            default:   y_o = even_i;
        endcase
    end

endmodule

// File: rtl/ilsr_top.sv
module ilsr_top
    import ilsr_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int HALF  = N / 2;
    localparam int LANES = 2;

    lane_e        phase_w;
    logic [W-1:0] lane_tail [LANES];

    ilsr_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam lane_e MY_LANE = (g == 0) ? LANE_EVEN : LANE_ODD;

        ilsr_lane #(
            .W     (W),
            .DEPTH (HALF)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .en_i   (phase_w == MY_LANE),
            .din_i  (din),
            .tail_o (lane_tail[g])
        );
    end

    ilsr_merge #(
        .W (W)
    ) u_merge (
        .sel_i  (phase_w),
        .even_i (lane_tail[0]),
        .odd_i  (lane_tail[1]),
        .y_o    (dout)
    );

endmodule

// File: rtl/ilsr_chk.sv
module ilsr_chk
    import ilsr_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] din,
    input logic [W-1:0] dout,
    input lane_e        phase,
    input logic [W-1:0] tail0,
    input logic [W-1:0] tail1
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] FILL_MAX = CW'(N);

    logic          live_q;
    logic [CW-1:0] fill_q;
    logic [W-1:0]  chain_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            fill_q <= '0;
            for (int k = 0; k < N; k++) chain_q[k] <= '0;
        end else begin
            live_q <= 1'b1;
            if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
            chain_q[0] <= din;
            for (int k = 1; k < N; k++) chain_q[k] <= chain_q[k-1];
        end
    end

    // R1
    delay_match_chk: assert property (@(posedge clk) disable iff (rst)
        dout == chain_q[N-1]);

    // R2
    fill_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_q < FILL_MAX) |-> (dout == '0));

    // R4
    phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (phase != $past(phase)));

    // R4
    even_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(phase) == LANE_ODD) |-> $stable(tail0));

    // R4
    odd_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(phase) == LANE_EVEN) |-> $stable(tail1));

    // R6
    out_known_chk: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(dout));

endmodule

bind ilsr_top ilsr_chk #(
    .W (W),
    .N (N)
) u_ilsr_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .dout  (dout),
    .phase (phase_w),
    .tail0 (lane_tail[0]),
    .tail1 (lane_tail[1])
);

// File: tb/test_ilsr_top.sv
module test_ilsr_top;
    localparam int W    = 8;
    localparam int N    = 8;
    localparam int HMAX = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int n_checks = 0;
    int n_fail   = 0;
    int c        = 0;
    bit finished = 1'b0;
    logic [W-1:0] hist [HMAX];

    always #10 clk = ~clk;

    ilsr_top #(.W(W), .N(N)) i_ilsr_top (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .dout (dout)
    );

    // Expected output in cycle cc: zero during fill, else input from N cycles back.
    function automatic logic [W-1:0] expect_out(int cc);
        if (cc < N) return '0;
        return hist[(cc - N) % HMAX];
    endfunction

    // One cycle: check this cycle's output, then present the next sample.
    task automatic step(input logic [W-1:0] v, input string tag);
        logic [W-1:0] exp_v;
        @(negedge clk);
        exp_v = expect_out(c);
        n_checks++;
        if (dout !== exp_v) begin
            n_fail++;
            $display("FAIL %s cycle %0d: dout=%h expected=%h", tag, c, dout, exp_v);
        end
        rst = 1'b0;
        din = v;
        hist[c % HMAX] = v;
        c++;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        din = '0;
        repeat (2) @(posedge clk);
        c = 0;
    endtask

    task automatic run_random(input int cnt, input string fill_tag, input string tag);
        for (int i = 0; i < cnt; i++) begin
            step(W'($urandom), (c < N) ? fill_tag : tag);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        apply_reset();

        // R2 reset fill, then R1 random stream
        run_random(4 * N, "R2", "R1");

        // R4 lone pulses on even and odd entry cycles
        apply_reset();
        for (int i = 0; i < 4 * N; i++) begin
            if (i == N + 2)      step(8'hA5, "R4");
            else if (i == N + 7) step(8'h3C, "R4");
            else                 step('0, (c < N) ? "R2" : "R4");
        end

        // R5 back-to-back distinct ramp
        for (int i = 0; i < 3 * N; i++) begin
            step(W'(i + 1), "R5");
        end

        // R6 full-width and walking-one patterns
        for (int i = 0; i < 2 * N; i++) begin
            step((i % 2 == 0) ? '1 : '0, "R6");
        end
        for (int i = 0; i < W + N; i++) begin
            step(W'(1) << (i % W), "R6");
        end

        // R3 reset while the line is full of data
        run_random(N + 3, "R1", "R1");
        apply_reset();
        run_random(3 * N, "R3", "R1");

        // R1 long random run
        run_random(2000, "R2", "R1");

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", c);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule